// File: doc/BRIEF.md
# HI/LO Multiply-Divide Interlock Unit

This unit executes multiply and divide operations whose 64-bit outcome lands in a pair of result registers, HI and LO. It also serves the four move operations that read or write those registers. Each result is computed and written in the cycle the operation is accepted. The unit does not model the arithmetic's real latency in hardware. Instead, a busy countdown is loaded on every multiply or divide, and any move touching HI or LO is held back until that countdown reaches zero.

Operations arrive on a valid/ready issue port. Back-pressure rules on that port:
- `op_ready` falls only for a move (read or write of HI/LO) presented while the countdown is non-zero.
- A requester that sees `op_ready` low must hold `op_valid`, `op_code` and the operands unchanged until a cycle with `op_ready` high.
- A multiply or divide is never back-pressured.

The read result has no ready of its own. It is presented combinationally on `res_data`, with `res_valid`, in the cycle a read move is accepted. The `stall` pin is the inverse of `op_ready`, kept as a plain status pin for the issuing pipeline.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, HI, LO and the countdown are zero, so a read move issued right after reset is accepted at once and returns 0.
- R2: A signed multiply (op_code 0) writes the upper half of the signed 2W-bit product of opnd_a and opnd_b to HI and the lower half to LO.
- R3: An unsigned multiply (op_code 1) does the same with both operands treated as unsigned.
- R4: A signed divide (op_code 2) writes the quotient, rounded toward zero, to LO and the remainder, which takes the dividend's sign, to HI. The most negative dividend divided by -1 yields a quotient equal to the dividend and a remainder of 0.
- R5: An unsigned divide (op_code 3) writes the unsigned quotient to LO and the unsigned remainder to HI.
- R6: Any divide with opnd_b equal to zero writes 0 to both HI and LO.
- R7: An accepted multiply loads the countdown with MUL_LAT (default 4). A move presented in every following cycle is stalled for exactly MUL_LAT cycles.
- R8: An accepted divide loads the countdown with DIV_LAT (default 32). A following move is stalled for exactly DIV_LAT cycles.
- R9: The write-HI move (op_code 6) and the write-LO move (op_code 7) copy opnd_a into the named register. They stall while the countdown is non-zero, and leave HI and LO unchanged in every stalled cycle.
- R10: A multiply or divide presented while the countdown runs is accepted at once, overwrites HI and LO, and restarts the countdown at its own latency.
- R11: The read-HI move (op_code 4) and the read-LO move (op_code 5) drive res_valid high and res_data with the register's value in their accepting cycle. res_valid is low in every other cycle.
- R12: stall is high, and op_ready low, exactly when op_valid is high, op_code is a move (op_code bit 2 set) and the countdown is non-zero. With op_valid low nothing changes but the countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented |
| op_ready | output | 1 | The presented operation is accepted this cycle |
| op_code | input | 3 | Operation: 0 mul signed, 1 mul unsigned, 2 div signed, 3 div unsigned, 4 read HI, 5 read LO, 6 write HI, 7 write LO |
| opnd_a | input | W | First operand; dividend; value for write moves |
| opnd_b | input | W | Second operand; divisor |
| stall | output | 1 | Move held back by the busy countdown |
| res_valid | output | 1 | Read move accepted; res_data is valid |
| res_data | output | W | HI or LO value for a read move |

## Verification
The bench builds the unit with its defaults: W of 32, MUL_LAT of 4 and DIV_LAT of 32. At these values the full 32-bit sign corners are in reach: the most negative dividend over -1, all-ones unsigned products, and zero divisors. The 32-cycle divide window is also long enough to re-issue a multiply mid-countdown and watch the stall window shrink to four cycles. Random streams mix all eight op codes with held, back-pressured moves. This exercises the countdown both at zero and mid-run.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  typedef enum logic [2:0] {
    OP_MUL_S = 3'd0,
    OP_MUL_U = 3'd1,
    OP_DIV_S = 3'd2,
    OP_DIV_U = 3'd3,
    OP_RD_HI = 3'd4,
    OP_RD_LO = 3'd5,
    OP_WR_HI = 3'd6,
    OP_WR_LO = 3'd7
  } hilo_op_e;

  function automatic logic op_is_move(input hilo_op_e op);
    return op[2];
  endfunction

  function automatic logic op_is_mul(input hilo_op_e op);
    return (op == OP_MUL_S) || (op == OP_MUL_U);
  endfunction

  function automatic logic op_is_div(input hilo_op_e op);
    return (op == OP_DIV_S) || (op == OP_DIV_U);
  endfunction

endpackage

// File: rtl/hilo_arith.sv
module hilo_arith
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  hilo_op_e       op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   hi_res,
  output logic [W-1:0]   lo_res
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] a_sx, b_sx, prod_s;
  logic        [PW-1:0] a_zx, b_zx, prod_u;
  logic signed [W-1:0]  quot_s, rem_s;
  logic        [W-1:0]  quot_u, rem_u;
  logic                 div_zero, div_ovf;

  always_comb begin
    a_sx   = $signed({{W{a[W-1]}}, a});
    b_sx   = $signed({{W{b[W-1]}}, b});
    a_zx   = {{W{1'b0}}, a};
    b_zx   = {{W{1'b0}}, b};
    prod_s = a_sx * b_sx;
    prod_u = a_zx * b_zx;
  end

  always_comb begin
    div_zero = (b == '0);
    div_ovf  = (a == MOST_NEG) && (b == {W{1'b1}});
    quot_s   = '0;
    rem_s    = '0;
    quot_u   = '0;
    rem_u    = '0;
    if (!div_zero) begin
      quot_u = a / b;
      rem_u  = a % b;
      if (div_ovf) begin
        quot_s = $signed(MOST_NEG);
        rem_s  = '0;
      end else begin
        quot_s = $signed(a) / $signed(b);
        rem_s  = $signed(a) % $signed(b);
      end
    end
  end

  always_comb begin
    unique case (op)
      OP_MUL_S: begin hi_res = prod_s[PW-1:W]; lo_res = prod_s[W-1:0]; end
      OP_MUL_U: begin hi_res = prod_u[PW-1:W]; lo_res = prod_u[W-1:0]; end
      OP_DIV_S: begin hi_res = rem_s;          lo_res = quot_s;        end
      OP_DIV_U: begin hi_res = rem_u;          lo_res = quot_u;        end
      default:  begin hi_res = a;              lo_res = a;             end
    endcase
  end

endmodule

// File: rtl/hilo_busy_timer.sv
module hilo_busy_timer #(
  parameter int MUL_LAT = 4,
  parameter int DIV_LAT = 32,
  localparam int MAX_LAT = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT,
  localparam int CNT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_mul,
  input  logic             load_div,
  output logic             busy,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MUL_CNT = CNT_W'(MUL_LAT);
  localparam logic [CNT_W-1:0] DIV_CNT = CNT_W'(DIV_LAT);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_LAT);

  always_ff @(posedge clk) begin
    if (!rst_n)             count <= '0;
    else if (load_div)      count <= DIV_CNT;
    else if (load_mul)      count <= MUL_CNT;
    else if (count != '0)   count <= count - 1'b1;
  end

  assign busy = (count != '0);

  // R7
  mul_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_mul && !load_div) |=> (count == MUL_CNT));
  // R8
  div_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_div |=> (count == DIV_CNT));
  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load_mul && !load_div) |=> (count == $past(count) - 1'b1));
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= MAX_CNT);

endmodule

// File: rtl/hilo_regs.sv
module hilo_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] hi_d,
  input  logic [W-1:0] lo_d,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi) hi_q <= hi_d;
      if (wr_lo) lo_q <= lo_d;
    end
  end

  // R12
  hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> $stable(hi_q));
  // R12
  hold_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> $stable(lo_q));

endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int W       = 32,
  parameter int MUL_LAT = 4,
  parameter int DIV_LAT = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         stall,
  output logic         res_valid,
  output logic [W-1:0] res_data
);
  localparam int MAX_LAT = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  hilo_op_e        op;
  logic            busy, accept, is_move;
  logic            load_mul, load_div, wr_hi, wr_lo;
  logic [W-1:0]    hi_res, lo_res, hi_q, lo_q;
  logic [CNT_W-1:0] count;

  assign op      = hilo_op_e'(op_code);
  assign is_move = op_is_move(op);
  assign stall   = op_valid && is_move && busy;
  assign op_ready = !stall;
  assign accept  = op_valid && !stall;

  assign load_mul = accept && op_is_mul(op);
  assign load_div = accept && op_is_div(op);
  assign wr_hi    = load_mul || load_div || (accept && op == OP_WR_HI);
  assign wr_lo    = load_mul || load_div || (accept && op == OP_WR_LO);

  hilo_arith #(.W(W)) u_arith (
    .op(op), .a(opnd_a), .b(opnd_b), .hi_res(hi_res), .lo_res(lo_res)
  );

  hilo_busy_timer #(.MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_mul(load_mul), .load_div(load_div),
    .busy(busy), .count(count)
  );

  hilo_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .hi_d(hi_res), .lo_d(lo_res), .hi_q(hi_q), .lo_q(lo_q)
  );

  assign res_valid = accept && (op == OP_RD_HI || op == OP_RD_LO);
  assign res_data  = (op == OP_RD_HI) ? hi_q : lo_q;

  // R9
  stalled_move_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(hi_q) && $stable(lo_q)));
  // R9
  wr_hi_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_WR_HI) |=> (hi_q == $past(opnd_a)));
  // R6
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_div && opnd_b == '0) |=> (hi_q == '0 && lo_q == '0));
  // R10
  muldiv_never_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !is_move) |-> op_ready);
  // R11
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (count == '0));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (hi_q == '0 && lo_q == '0 && count == '0));

endmodule

// File: tb/hilo_muldiv_bench.sv
module hilo_muldiv_bench;
  localparam int W = 32, MUL_LAT = 4, DIV_LAT = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic op_ready, stall, res_valid;
  logic [W-1:0] res_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] m_hi = '0, m_lo = '0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  hilo_muldiv #(.W(W), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)) u_hilo_muldiv (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .stall(stall),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [63:0] m_mul(bit sgn, logic [31:0] a, logic [31:0] b);
    longint sa, sb;
    if (sgn) begin
      sa = longint'($signed(a)); sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  // returns {remainder, quotient}
  function automatic logic [63:0] m_div(bit sgn, logic [31:0] a, logic [31:0] b);
    int sa, sb, q, r;
    if (b == 0) return 64'h0;
    if (!sgn) return {a % b, a / b};
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return {32'h0, 32'h8000_0000};
    sa = $signed(a); sb = $signed(b);
    q = sa / sb; r = sa % sb;
    return {r, q};
  endfunction

  function automatic string req_of(logic [2:0] op, logic [31:0] b);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return (b == 0) ? "R6" : "R4";
      3'd3: return (b == 0) ? "R6" : "R5";
      3'd4, 3'd5: return "R11";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check just after, update model for the next edge.
  task automatic step(bit v, logic [2:0] op, logic [31:0] a, logic [31:0] b,
                      string req, output bit stl);
    bit exp_stl, exp_rv;
    logic [63:0] r;
    @(negedge clk);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
    #1;
    exp_stl = v && op[2] && (m_cnt != 0);
    exp_rv  = v && !exp_stl && (op == 3'd4 || op == 3'd5);
    chk(stall == exp_stl, (v && op[2]) ? req : "R12", "stall", 64'(stall), 64'(exp_stl));
    chk(op_ready == !exp_stl, "R12", "op_ready", 64'(op_ready), 64'(!exp_stl));
    chk(res_valid == exp_rv, "R11", "res_valid", 64'(res_valid), 64'(exp_rv));
    if (exp_rv)
      chk(res_data == ((op == 3'd4) ? m_hi : m_lo), req, "res_data",
          64'(res_data), 64'((op == 3'd4) ? m_hi : m_lo));
    stl = exp_stl;
    if (v && !exp_stl) begin
      case (op)
        3'd0, 3'd1: begin r = m_mul(op == 3'd0, a, b); {m_hi, m_lo} = r; m_cnt = MUL_LAT; end
        3'd2, 3'd3: begin r = m_div(op == 3'd2, a, b); {m_hi, m_lo} = r; m_cnt = DIV_LAT; end
        3'd6: begin m_hi = a; if (m_cnt > 0) m_cnt--; end
        3'd7: begin m_lo = a; if (m_cnt > 0) m_cnt--; end
        default: if (m_cnt > 0) m_cnt--;
      endcase
    end else if (m_cnt > 0) m_cnt--;
  endtask

  // Holds the operation until accepted; returns the number of stalled cycles.
  task automatic issue(logic [2:0] op, logic [31:0] a, logic [31:0] b, string req,
                       output int nstall);
    bit s;
    nstall = 0;
    do begin
      step(1'b1, op, a, b, req, s);
      if (s) nstall++;
    end while (s);
  endtask

  task automatic idle(int n);
    bit s;
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, '0, "R12", s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit s;
    logic [2:0] pend_op;
    logic [31:0] pend_a, pend_b;
    bit pending;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: no stall and zero contents right after reset
    issue(3'd4, 0, 0, "R1", n); chk(n == 0, "R1", "stalls after reset", 64'(n), 0);
    issue(3'd5, 0, 0, "R1", n);

    // R2 and R7: signed multiply, then a read waits MUL_LAT cycles
    issue(3'd0, 32'hFFFF_FFFD, 32'd7, "R2", n);
    issue(3'd4, 0, 0, "R2", n); chk(n == MUL_LAT, "R7", "mul stall count", 64'(n), MUL_LAT);
    issue(3'd5, 0, 0, "R2", n);
    issue(3'd0, 32'h8000_0000, 32'h8000_0000, "R2", n);
    idle(MUL_LAT); issue(3'd4, 0, 0, "R2", n); issue(3'd5, 0, 0, "R2", n);

    // R3: unsigned multiply of all-ones
    issue(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3", n);
    idle(MUL_LAT); issue(3'd4, 0, 0, "R3", n); issue(3'd5, 0, 0, "R3", n);

    // R4 and R8: signed divide, stall DIV_LAT cycles
    issue(3'd2, 32'hFFFF_FFF9, 32'd2, "R4", n);
    issue(3'd5, 0, 0, "R4", n); chk(n == DIV_LAT, "R8", "div stall count", 64'(n), DIV_LAT);
    issue(3'd4, 0, 0, "R4", n);
    issue(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R4", n);
    idle(DIV_LAT); issue(3'd5, 0, 0, "R4", n); issue(3'd4, 0, 0, "R4", n);

    // R5: unsigned divide
    issue(3'd3, 32'hFFFF_FFF9, 32'd10, "R5", n);
    idle(DIV_LAT); issue(3'd5, 0, 0, "R5", n); issue(3'd4, 0, 0, "R5", n);

    // R6: divide by zero clears both
    issue(3'd2, 32'h1234_5678, 32'd0, "R6", n);
    idle(DIV_LAT); issue(3'd4, 0, 0, "R6", n); issue(3'd5, 0, 0, "R6", n);

    // R9: write moves stall while busy and change nothing until accepted
    issue(3'd1, 32'd3, 32'd5, "R3", n);
    issue(3'd6, 32'hCAFE_0001, 0, "R9", n);
    chk(n == MUL_LAT, "R9", "write move stall count", 64'(n), MUL_LAT);
    issue(3'd7, 32'hBEEF_0002, 0, "R9", n);
    issue(3'd4, 0, 0, "R9", n); issue(3'd5, 0, 0, "R9", n);

    // R10: a multiply mid-divide restarts the countdown at MUL_LAT
    issue(3'd3, 32'd100, 32'd7, "R5", n);
    idle(5);
    issue(3'd0, 32'd6, 32'd7, "R10", n);
    chk(n == 0, "R10", "mul accepted while busy", 64'(n), 0);
    issue(3'd4, 0, 0, "R10", n); chk(n == MUL_LAT, "R10", "restarted stall", 64'(n), MUL_LAT);
    issue(3'd5, 0, 0, "R10", n);

    // R12: idle cycles during a countdown never stall
    issue(3'd2, 32'd50, 32'd3, "R4", n);
    idle(DIV_LAT + 2);

    // Random stream, moves held while back-pressured
    pending = 0;
    for (int i = 0; i < 4000; i++) begin
      if (!pending) begin
        pend_op = 3'($urandom_range(0, 7));
        pend_a  = $urandom();
        case ($urandom_range(0, 3))
          0: pend_b = 32'd0;
          1: pend_b = 32'($urandom_range(1, 9));
          2: pend_b = 32'hFFFF_FFFF;
          default: pend_b = $urandom();
        endcase
        if ($urandom_range(0, 3) == 0) begin
          step(1'b0, 3'd0, '0, '0, "R12", s);
          continue;
        end
      end
      step(1'b1, pend_op, pend_a, pend_b, req_of(pend_op, pend_b), s);
      pending = s;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule